// File: doc/BRIEF.md
# Show-Ahead Synchronous FIFO

A single-clock first-in first-out buffer whose oldest stored word is always present on the read data output whenever the buffer holds anything. The consumer does not request data; it looks at the output, and when it has taken the word it raises the read acknowledge for one clock. On the next clock edge the entry is removed and the following word takes its place on the output.

Producers push one word per clock by holding the write strobe high. The block reports empty, full and a fill count. Width and depth are parameters. The depth must be a power of two so that the pointers wrap by simple overflow. The default configuration is 16-bit words, 128 deep.

Top module: `showahead_fifo`

## Requirements
- R1: A synchronous active-high reset leaves the buffer with `empty`=1, `full`=0 and `fill_count`=0 from the first clock edge after reset is sampled. This holds even if words were stored before the reset.
- R2: While `empty`=0, `rd_data` shows the oldest stored word without any read acknowledge. After a write into an empty buffer, that word is on `rd_data` in the cycle after the write edge.
- R3: One cycle of `rd_ack` with `empty`=0 removes the presented word. After that edge, the next older word is on `rd_data`. Words leave in the order they were written.
- R4: `empty` falls after the edge of the first write into an empty buffer. It rises after the edge at which the last stored word is acknowledged.
- R5: With `wr_en` held high and the buffer not full, one word is stored per clock, and `fill_count` rises by exactly 1 per edge.
- R6: A write while `full`=1 and `rd_ack`=0 is dropped. `fill_count`, `rd_data` and the stored words stay unchanged.
- R7: A read acknowledge while `empty`=1 is ignored. If `wr_en` is also high in that cycle, the write is still stored and the count becomes 1.
- R8: A simultaneous write and acknowledge while 0 < `fill_count` < DEPTH keeps `fill_count` unchanged. The head is removed and the new word is appended at the tail.
- R9: `full`=1 exactly when `fill_count` equals DEPTH. A simultaneous write and acknowledge while full removes the head and drops the write, so the count becomes DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle high |
| wr_data | input | DATA_W | Word to store |
| rd_ack | input | 1 | Acknowledge that the presented word was taken |
| rd_data | output | DATA_W | Oldest stored word, valid while not empty |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| fill_count | output | log2(DEPTH)+1 | Number of stored words |

## Verification
The bench targets the edges of the fill range.

- **Acknowledge on an empty buffer.** If the design honoured it, the count would wrap to all ones.
- **Write and acknowledge together into an empty buffer.** A design that let both through would lose the word, or show it as gone.
- **Write into a full buffer.** If the design took the write, it would overwrite the head, and a corrupted word would appear during the drain.
- **Write and acknowledge together while full.** A design that accepted the write here would keep the count at DEPTH instead of DEPTH-1.
- **Data order and timing.** Output order and the cycle at which each word appears are checked against a model. This catches a registered read path, which would show the old head one cycle too long.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Operation applied at one clock edge after qualification.
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } fifo_op_e;

    // Pointer width for a given depth.
    function automatic int unsigned idx_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

    function automatic logic op_pushes(input fifo_op_e op);
        return (op == OP_PUSH) || (op == OP_SWAP);
    endfunction

    function automatic logic op_pops(input fifo_op_e op);
        return (op == OP_POP) || (op == OP_SWAP);
    endfunction

endpackage

// File: rtl/sfifo_gate.sv
module sfifo_gate
    import sfifo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_req,
    input  logic     rd_req,
    input  logic     is_full,
    input  logic     is_empty,
    output fifo_op_e op
);

    logic push_ok;
    logic pop_ok;

    // Writes are refused when full; acknowledges are refused when empty.
    assign push_ok = wr_req && !is_full;
    assign pop_ok  = rd_req && !is_empty;

    always_comb begin
        unique case ({pop_ok, push_ok})
            2'b01:   op = OP_PUSH;
            2'b10:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_HOLD;
        endcase
    end

    // R7: nothing is removed from an empty buffer
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
        is_empty |-> !op_pops(op));

    // R6: nothing is stored into a full buffer
    p_no_push_full_r6: assert property (@(posedge clk) disable iff (rst)
        is_full |-> !op_pushes(op));

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = idx_bits(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_op_e      op,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output logic [CW-1:0] count,
    output logic          is_empty,
    output logic          is_full
);

    logic [CW-1:0] count_nx;

    always_comb begin
        unique case (op)
            OP_PUSH: count_nx = count + CW'(1);
            OP_POP:  count_nx = count - CW'(1);
            default: count_nx = count;
        endcase
    end

    // Pointers wrap by overflow; depth is a power of two.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx   <= '0;
            rd_idx   <= '0;
            count    <= '0;
            is_empty <= 1'b1;
            is_full  <= 1'b0;
        end else begin
            if (op_pushes(op)) wr_idx <= wr_idx + AW'(1);
            if (op_pops(op))   rd_idx <= rd_idx + AW'(1);
            count    <= count_nx;
            is_empty <= (count_nx == '0);
            is_full  <= (count_nx == CW'(DEPTH));
        end
    end

    initial begin
        assert ((DEPTH & (DEPTH - 1)) == 0 && DEPTH >= 2)
            else $error("sfifo_ctrl: DEPTH must be a power of two, at least 2");
    end

    // R9: full flag matches count at depth
    p_full_at_depth_r9: assert property (@(posedge clk) disable iff (rst)
        is_full == (count == CW'(DEPTH)));

    // R4: empty flag matches zero count
    p_empty_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
        is_empty == (count == '0));

    // R5: pointer distance tracks the stored word count
    p_ptr_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_idx - rd_idx) == count[AW-1:0]);

    // R9: count never exceeds depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 128,
    localparam int unsigned AW    = idx_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Show-ahead: the head cell is driven combinationally.
    assign rdata = cells[raddr];

endmodule

// File: rtl/showahead_fifo.sv
module showahead_fifo
    import sfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 128,
    localparam int unsigned AW    = idx_bits(DEPTH),
    localparam int unsigned CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic [CW-1:0]     fill_count
);

    fifo_op_e      op;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;

    sfifo_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_en),
        .rd_req   (rd_ack),
        .is_full  (full),
        .is_empty (empty),
        .op       (op)
    );

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .count    (fill_count),
        .is_empty (empty),
        .is_full  (full)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (op_pushes(op)),
        .waddr (wr_idx),
        .wdata (wr_data),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    // R1: reset empties the buffer
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (empty && !full && fill_count == '0));

    // R2: first word written into an empty buffer is shown at once
    p_show_first_r2: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en) |=> (!empty && rd_data == $past(wr_data)));

    // R6: write into a full buffer without acknowledge changes nothing
    p_drop_full_write_r6: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_ack) |=> ($stable(fill_count) && $stable(rd_data)));

    // R7: acknowledge on an empty buffer without write keeps it empty
    p_ignore_empty_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_ack && !wr_en) |=> (empty && fill_count == '0));

    // R8: balanced write and acknowledge keep the count
    p_swap_count_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_ack && !empty && !full) |=> $stable(fill_count));

    // R9: write and acknowledge while full leaves one free slot
    p_full_swap_r9: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && rd_ack) |=> (!full && fill_count == CW'(DEPTH - 1)));

endmodule

// File: tb/test_showahead_fifo.sv
module test_showahead_fifo;

    localparam int DW = 16;
    localparam int DP = 8;
    localparam int CW = 4;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [DW-1:0] wd;
        logic [CW-1:0] cnt;
        logic          emp;
        logic          ful;
        logic [DW-1:0] head;
    } vec_t;

    localparam int NV = 10;
    // Expected state after the clock edge of each vector.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 16'hA001, 4'd1, 1'b0, 1'b0, 16'hA001},
        '{1'b1, 1'b0, 16'hA002, 4'd2, 1'b0, 1'b0, 16'hA001},
        '{1'b1, 1'b0, 16'hA003, 4'd3, 1'b0, 1'b0, 16'hA001},
        '{1'b0, 1'b1, 16'h0000, 4'd2, 1'b0, 1'b0, 16'hA002},
        '{1'b1, 1'b1, 16'hA004, 4'd2, 1'b0, 1'b0, 16'hA003},
        '{1'b0, 1'b1, 16'h0000, 4'd1, 1'b0, 1'b0, 16'hA004},
        '{1'b0, 1'b1, 16'h0000, 4'd0, 1'b1, 1'b0, 16'h0000},
        '{1'b0, 1'b1, 16'h0000, 4'd0, 1'b1, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 16'hA005, 4'd1, 1'b0, 1'b0, 16'hA005},
        '{1'b0, 1'b0, 16'h0000, 4'd1, 1'b0, 1'b0, 16'hA005}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data;
    logic          empty;
    logic          full;
    logic [CW-1:0] fill_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    showahead_fifo #(.DATA_W(DW), .DEPTH(DP)) i_showahead_fifo (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .empty      (empty),
        .full       (full),
        .fill_count (fill_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample just after the next rising edge.
    task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en   = w;
        rd_ack  = r;
        wr_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst    = 1'b1;
        wr_en  = 1'b0;
        rd_ack = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 empty", 32'(empty), 32'd1);
        check("R1 full", 32'(full), 32'd0);
        check("R1 count", 32'(fill_count), 32'd0);

        // Vector walk: R2/R3/R4/R5/R7/R8
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].rd, VEC[i].wd);
            check($sformatf("R4 vec%0d empty", i), 32'(empty), 32'(VEC[i].emp));
            check($sformatf("R8 vec%0d count", i), 32'(fill_count), 32'(VEC[i].cnt));
            check($sformatf("R9 vec%0d full", i), 32'(full), 32'(VEC[i].ful));
            if (!VEC[i].emp)
                check($sformatf("R2/R3 vec%0d head", i), 32'(rd_data), 32'(VEC[i].head));
        end
        step(1'b0, 1'b0, '0);

        // R5: burst fill, one word per clock
        do_reset();
        for (int i = 0; i < DP; i++) begin
            step(1'b1, 1'b0, DW'(16'hB000 + i));
            check("R5 count per clock", 32'(fill_count), 32'(i + 1));
            check("R9 full at depth only", 32'(full), 32'(i + 1 == DP));
            check("R2 head during fill", 32'(rd_data), 32'h0000B000);
        end

        // R6: write while full is dropped
        step(1'b1, 1'b0, 16'hDEAD);
        check("R6 count after full write", 32'(fill_count), 32'(DP));
        check("R6 head after full write", 32'(rd_data), 32'h0000B000);

        // R3: drain in order, no corrupted word
        for (int i = 0; i < DP; i++) begin
            check("R3 drain order", 32'(rd_data), 32'(16'hB000 + i));
            step(1'b0, 1'b1, '0);
        end
        check("R4 empty after last ack", 32'(empty), 32'd1);
        check("R7 count after drain", 32'(fill_count), 32'd0);
        step(1'b0, 1'b1, '0);
        check("R7 ack on empty", 32'(fill_count), 32'd0);

        // R9: write and acknowledge together while full
        for (int i = 0; i < DP; i++) step(1'b1, 1'b0, DW'(16'hC000 + i));
        check("R9 full before swap", 32'(full), 32'd1);
        step(1'b1, 1'b1, 16'hEEEE);
        check("R9 count after full swap", 32'(fill_count), 32'(DP - 1));
        check("R9 full after full swap", 32'(full), 32'd0);
        check("R9 head after full swap", 32'(rd_data), 32'h0000C001);
        for (int i = 1; i < DP; i++) step(1'b0, 1'b1, '0);
        check("R6 dropped word absent", 32'(empty), 32'd1);

        // R1: reset while holding data
        step(1'b1, 1'b0, 16'h1234);
        step(1'b1, 1'b0, 16'h5678);
        do_reset();
        check("R1 reset mid-use empty", 32'(empty), 32'd1);
        check("R1 reset mid-use count", 32'(fill_count), 32'd0);
        step(1'b1, 1'b0, 16'h9ABC);
        check("R2 head after reset", 32'(rd_data), 32'h00009ABC);
        step(1'b0, 1'b0, '0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule